// File: doc/BRIEF.md
# Sample Strobe Generator with Channel-Count Rate Limits

This block makes the one-cycle sample-enable pulse for a 16-channel logic capture front end. Two base timebases, nominally 100 MHz and 160 MHz, reach the block as tick enables in a single clock domain. A select bit chooses one of them, and an 8-bit divider turns its ticks into a strobe that fires once every N ticks, where N runs from 1 to 256.

The block also checks whether the requested setting is legal. It takes the population count of a 16-bit channel-enable mask and places that count in a bandwidth band. The allowed sample rate drops as the band rises. The check does not divide in hardware. Each timebase has a small table of minimum ratios, one per band, and the divider ratio is compared against the entry for the current band. If the ratio is too small, `cfg_error` rises and no strobes are sent until a later register write makes the setting legal.

Configuration arrives as single-cycle register writes. No data stream passes through the block, so it has no valid/ready interface. All pins are plain control and status.

Top module: `sample_strobe_gen`

## Requirements
- R1: After reset, `sample_stb` and `cfg_error` are low. The select bit, the divider and the mask are all zero, which gives ratio 1 on timebase 0.
- R2: A write with `cfg_we` high updates one register, chosen by `cfg_addr`:
  - address 0: select bit (`cfg_wdata[0]`)
  - address 1: divider
  - address 2: mask channels 0..7
  - address 3: mask channels 8..15
- R3: The ratio is the divider value plus one. While no error is present and the selected tick is held high, `sample_stb` is a single-cycle pulse that repeats every ratio ticks.
- R4: A write to address 0 or address 1 reloads the count. The first strobe appears in the cycle after the (divider+1)-th selected tick that follows the write.
- R5: Select 0 counts `base0_tick` and select 1 counts `base1_tick`. The tick of the unselected timebase has no effect, and cycles without a selected tick do not advance the count.
- R6: The channel count is the number of ones in the 16-bit mask, and bits in either mask byte count.
- R7: The bandwidth limits by number of enabled channels are:
  - 0 to 3 channels: 100 MHz
  - 4 or more: 50 MHz
  - 7 or more: 40 MHz
  - 8 or more: 32 MHz
  - 10 or more: 25 MHz
  - 13 or more: 16 MHz
  
  `cfg_error` is high exactly when the timebase frequency divided by the ratio exceeds the limit for the current band.
- R8: While `cfg_error` is high, no strobe is produced. Once a write brings the setting back within limits, strobes resume.
- R9: `cfg_error` changes only in the cycle after a register write.
- R10: A write to a mask byte does not reload the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base0_tick | input | 1 | Tick enable of the 100 MHz timebase |
| base1_tick | input | 1 | Tick enable of the 160 MHz timebase |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| sample_stb | output | 1 | One-cycle sample enable |
| cfg_error | output | 1 | Setting exceeds the rate limit for the channel count |

## Verification
Four properties are checked on every cycle:
- no strobe follows a cycle in which `cfg_error` was high;
- no strobe follows a cycle without any tick;
- no strobe appears two cycles after a divider write with a nonzero value;
- `cfg_error` holds steady across cycles without a write.

Only the directed scenarios can show the rest:
- the exact position of the first strobe and the strobe period;
- that timebase selection ignores the other tick;
- that mask writes leave the count alone;
- every band boundary of the rate table on both timebases.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  localparam int NUM_BANDS = 6;

  // Band index from the number of enabled channels.
  function automatic int band_of(input int nch);
    if (nch >= 13) return 5;
    if (nch >= 10) return 4;
    if (nch >= 8)  return 3;
    if (nch >= 7)  return 2;
    if (nch >= 4)  return 1;
    return 0;
  endfunction

  // Rate ceiling of each band, in MHz.
  function automatic int band_limit_mhz(input int band);
    case (band)
      0:       return 100;
      1:       return 50;
      2:       return 40;
      3:       return 32;
      4:       return 25;
      default: return 16;
    endcase
  endfunction

  // Smallest ratio that keeps base/ratio at or below the band ceiling.
  function automatic int min_ratio(input int base_mhz, input int band);
    int lim;
    lim = band_limit_mhz(band);
    return (base_mhz + lim - 1) / lim;
  endfunction
endpackage

// File: rtl/ssg_cfg_regs.sv
module ssg_cfg_regs #(
  parameter int DIV_W  = 8,
  parameter int CH_N   = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [CH_N-1:0]   mask_q,
  output logic              reload,
  output logic [DIV_W-1:0]  reload_val
);
  localparam int MASK_BYTES = (CH_N + DATA_W - 1) / DATA_W;
  localparam int MASK_BASE  = 2;

  logic [MASK_BYTES*DATA_W-1:0] mask_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      div_q <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(0)) sel_q <= wdata[0];
      if (addr == ADDR_W'(1)) div_q <= wdata[DIV_W-1:0];
    end
  end

  for (genvar b = 0; b < MASK_BYTES; b++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)
        mask_all[b*DATA_W +: DATA_W] <= '0;
      else if (we && addr == ADDR_W'(MASK_BASE + b))
        mask_all[b*DATA_W +: DATA_W] <= wdata;
    end
  end

  assign mask_q = mask_all[CH_N-1:0];

  always_comb begin
    reload     = we && (addr == ADDR_W'(0) || addr == ADDR_W'(1));
    reload_val = (addr == ADDR_W'(1)) ? wdata[DIV_W-1:0] : div_q;
  end
endmodule

// File: rtl/ssg_rate_check.sv
module ssg_rate_check
  import ssg_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int CH_N    = 16,
  parameter int TB0_MHZ = 100,
  parameter int TB1_MHZ = 160
) (
  input  logic             sel,
  input  logic [DIV_W-1:0] div,
  input  logic [CH_N-1:0]  mask,
  output logic             err
);
  localparam int CNT_W = $clog2(CH_N + 1);
  localparam int RAT_W = DIV_W + 1;

  logic [RAT_W-1:0] min_tb0 [NUM_BANDS];
  logic [RAT_W-1:0] min_tb1 [NUM_BANDS];

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_tab
    assign min_tb0[b] = RAT_W'(min_ratio(TB0_MHZ, b));
    assign min_tb1[b] = RAT_W'(min_ratio(TB1_MHZ, b));
  end

  logic [CNT_W-1:0] nch;
  logic [2:0]       band;
  logic [RAT_W-1:0] ratio;
  logic [RAT_W-1:0] floor_r;

  always_comb begin
    nch = '0;
    for (int i = 0; i < CH_N; i++) nch = nch + CNT_W'(mask[i]);
  end

  always_comb begin
    if      (nch >= CNT_W'(13)) band = 3'd5;
    else if (nch >= CNT_W'(10)) band = 3'd4;
    else if (nch >= CNT_W'(8))  band = 3'd3;
    else if (nch >= CNT_W'(7))  band = 3'd2;
    else if (nch >= CNT_W'(4))  band = 3'd1;
    else                        band = 3'd0;
    ratio   = {1'b0, div} + RAT_W'(1);
    floor_r = sel ? min_tb1[band] : min_tb0[band];
    err     = ratio < floor_r;
  end
endmodule

// File: rtl/ssg_divider.sv
module ssg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             block,
  input  logic             reload,
  input  logic [DIV_W-1:0] reload_val,
  input  logic [DIV_W-1:0] div,
  output logic             stb
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb   <= 1'b0;
    end else begin
      stb <= !reload && tick && (cnt_q == '0) && !block;
      if (reload)
        cnt_q <= reload_val;
      else if (tick)
        cnt_q <= (cnt_q == '0) ? div : cnt_q - DIV_W'(1);
    end
  end
endmodule

// File: rtl/sample_strobe_gen.sv
module sample_strobe_gen #(
  parameter int DIV_W   = 8,
  parameter int CH_N    = 16,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int TB0_MHZ = 100,
  parameter int TB1_MHZ = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base0_tick,
  input  logic              base1_tick,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              sample_stb,
  output logic              cfg_error
);
  logic             sel_q;
  logic [DIV_W-1:0] div_q;
  logic [CH_N-1:0]  mask_q;
  logic             reload;
  logic [DIV_W-1:0] reload_val;
  logic             tick;

  ssg_cfg_regs #(.DIV_W(DIV_W), .CH_N(CH_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sel_q(sel_q), .div_q(div_q), .mask_q(mask_q),
    .reload(reload), .reload_val(reload_val)
  );

  ssg_rate_check #(.DIV_W(DIV_W), .CH_N(CH_N), .TB0_MHZ(TB0_MHZ), .TB1_MHZ(TB1_MHZ)) u_chk_rate (
    .sel(sel_q), .div(div_q), .mask(mask_q), .err(cfg_error)
  );

  assign tick = sel_q ? base1_tick : base0_tick;

  ssg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .block(cfg_error),
    .reload(reload), .reload_val(reload_val), .div(div_q), .stb(sample_stb)
  );
endmodule

// File: rtl/ssg_checker.sv
module ssg_checker #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int DIV_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              base0_tick,
  input logic              base1_tick,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              sample_stb,
  input logic              cfg_error
);
  AST_ERR_BLOCKS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> !sample_stb); // R8

  AST_NO_TICK_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (!base0_tick && !base1_tick) |=> !sample_stb); // R5

  AST_DIV_WRITE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_W'(DIV_ADDR) && cfg_wdata != '0) |=> ##1 !sample_stb); // R4

  AST_ERR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_error)); // R9
endmodule

bind sample_strobe_gen ssg_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_ADDR(1)) u_ssg_checker (
  .clk(clk), .rst_n(rst_n), .base0_tick(base0_tick), .base1_tick(base1_tick),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .sample_stb(sample_stb), .cfg_error(cfg_error)
);

// File: tb/tb_sample_strobe_gen.sv
module tb_sample_strobe_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base0_tick = 1'b0;
  logic       base1_tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       sample_stb;
  logic       cfg_error;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .base0_tick(base0_tick), .base1_tick(base1_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sample_stb(sample_stb), .cfg_error(cfg_error)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Starts and ends just after a falling edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic configure(input bit sel, input logic [15:0] mask, input logic [7:0] div);
    wr(2'd2, mask[7:0]);
    wr(2'd3, mask[15:8]);
    wr(2'd0, {7'd0, sel});
    wr(2'd1, div);
  endtask

  // mode: 0 low, 1 high, 2 high on odd cycle index
  task automatic measure(input int w, input int m0, input int m1,
                         input int exp_first, input int exp_count, input string tag);
    int first = -1;
    int count = 0;
    for (int i = 1; i <= w; i++) begin
      base0_tick = (m0 == 1) || (m0 == 2 && (i % 2) == 1);
      base1_tick = (m1 == 1) || (m1 == 2 && (i % 2) == 1);
      @(negedge clk);
      if (sample_stb) begin
        count++;
        if (first < 0) first = i;
      end
    end
    chk({tag, " first strobe"}, first, exp_first);
    chk({tag, " strobe count"}, count, exp_count);
  endtask

  task automatic t_reset();
    chk("R1 stb after reset", int'(sample_stb), 0);
    chk("R1 error after reset", int'(cfg_error), 0);
    measure(5, 1, 0, 1, 5, "R1 default ratio 1");
  endtask

  task automatic t_period();
    configure(1'b0, 16'h0003, 8'd4);
    chk("R2 legal setting", int'(cfg_error), 0);
    measure(23, 1, 0, 5, 23 / 5, "R3 R4 ratio 5");
    configure(1'b0, 16'h0003, 8'd4);
    measure(40, 2, 0, 9, 41 / 10, "R5 sparse ticks");
  endtask

  task automatic t_select();
    configure(1'b1, 16'h0000, 8'd3);
    measure(12, 1, 0, -1, 0, "R5 unselected tick ignored");
    measure(6, 1, 1, 4, 1, "R5 selected tick counted");
    wr(2'd0, 8'd1);
    measure(9, 0, 1, 4, 2, "R4 reload on select write");
  endtask

  task automatic t_mask_no_reload();
    configure(1'b0, 16'h0001, 8'd5);
    measure(3, 1, 0, -1, 0, "R10 before mask write");
    wr(2'd2, 8'h01);
    measure(8, 1, 0, 2, 2, "R10 mask write keeps count");
  endtask

  task automatic lim(input bit sel, input logic [15:0] mask, input logic [7:0] div,
                     input bit exp_err, input string tag);
    configure(sel, mask, div);
    chk({tag, " error flag"}, int'(cfg_error), int'(exp_err));
    measure(12, sel ? 0 : 1, sel ? 1 : 0, exp_err ? -1 : int'(div) + 1,
            exp_err ? 0 : 12 / (int'(div) + 1), {tag, " strobes"});
    chk({tag, " error held (R9)"}, int'(cfg_error), int'(exp_err));
  endtask

  task automatic t_limits();
    lim(1'b0, 16'h000F, 8'd0, 1'b1, "R7 4ch tb0 ratio1");
    lim(1'b0, 16'h000F, 8'd1, 1'b0, "R8 4ch tb0 ratio2");
    lim(1'b1, 16'h0000, 8'd0, 1'b1, "R7 0ch tb1 ratio1");
    lim(1'b1, 16'h0000, 8'd1, 1'b0, "R7 0ch tb1 ratio2");
    lim(1'b0, 16'h007F, 8'd1, 1'b1, "R7 7ch tb0 ratio2");
    lim(1'b0, 16'h007F, 8'd2, 1'b0, "R7 7ch tb0 ratio3");
    lim(1'b0, 16'h00FF, 8'd2, 1'b1, "R7 8ch tb0 ratio3");
    lim(1'b0, 16'h00FF, 8'd3, 1'b0, "R7 8ch tb0 ratio4");
    lim(1'b0, 16'h03FF, 8'd3, 1'b0, "R7 10ch tb0 ratio4");
    lim(1'b1, 16'h03FF, 8'd5, 1'b1, "R7 10ch tb1 ratio6");
    lim(1'b1, 16'h03FF, 8'd6, 1'b0, "R7 10ch tb1 ratio7");
    lim(1'b0, 16'h1FFF, 8'd5, 1'b1, "R7 13ch tb0 ratio6");
    lim(1'b0, 16'h1FFF, 8'd6, 1'b0, "R7 13ch tb0 ratio7");
    lim(1'b1, 16'hFFFF, 8'd8, 1'b1, "R7 16ch tb1 ratio9");
    lim(1'b1, 16'hFFFF, 8'd9, 1'b0, "R7 16ch tb1 ratio10");
    lim(1'b0, 16'h1F00, 8'd0, 1'b1, "R6 high byte counted");
    lim(1'b0, 16'h1F00, 8'd1, 1'b0, "R8 error clears");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period();
    t_select();
    t_mask_no_reload();
    t_limits();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule